// File: doc/BRIEF.md
# Byte-Serial to RGB Pixel Assembler

This block sits between an 8-bit host parallel port and the RGB input of a TFT panel. The host sends each pixel as a short burst of bytes, one per pixel clock, together with active-low horizontal and vertical sync strobes and a per-byte valid flag. The block joins those bytes into one parallel pixel word. It presents that word with a one-cycle data-enable pulse.

The byte format is set by a static input. It is either RGB565, sent as two bytes per pixel, or RGB888, sent as three bytes per pixel. A second static input selects how the pixel is driven onto the 18-bit output bus: as a 16-bit word, or widened to 18 bits. The syncs pass through a delay line whose length matches the data path latency for the chosen format. Sync and data therefore leave the block aligned. The host only has to start its first active byte that many clocks after its sync edge. The byte phase is cleared on every horizontal sync falling edge, so a lost or extra byte never corrupts more than one line.

Top module: `byte_pixel_assembler`

## Requirements
- R1: With fmt_i=0 (RGB565), two accepted bytes form one pixel, most significant byte first. With wide_i=0, rgb_o = {2'b00, hi, lo}, so red is in bits 15:11, green in bits 10:5 and blue in bits 4:0.
- R2: With fmt_i=1 (RGB888), three accepted bytes arrive as red, green, blue. With wide_i=0, rgb_o = {2'b00, R[7:3], G[7:2], B[7:3]}.
- R3: With wide_i=1, rgb_o holds 6-bit red in bits 17:12, green in 11:6 and blue in 5:0. RGB888 gives {R[7:2], G[7:2], B[7:2]}. RGB565 widens its 5-bit red and blue by repeating each one's MSB as the new LSB.
- R4: If the first byte of a pixel is sampled at clock edge t and the bytes follow back to back, the pixel appears on rgb_o with de_o high after edge t+3 in RGB565 and after edge t+5 in RGB888.
- R5: hs_n_o and vs_n_o repeat hs_n_i and vs_n_i delayed by 3 clocks in RGB565 and by 5 clocks in RGB888.
- R6: de_o is high for exactly one cycle per completed pixel and is never high in two consecutive cycles.
- R7: Bytes with byte_vld_i=0 are not counted. rgb_o holds its last pixel, and de_o stays low, until the last byte of the next pixel has passed the pipeline.
- R8: A falling edge on hs_n_i clears the byte phase. A byte accepted in that same cycle counts as the first byte of a pixel.
- R9: While rst_ni is low, rgb_o is 0, de_o is 0, and hs_n_o and vs_n_o are 1.
- R10: A line of 320 back-to-back RGB565 pixels gives exactly 320 de_o pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock, one byte per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 1 | Static byte format: 0 = RGB565, 1 = RGB888 |
| wide_i | input | 1 | Static output width: 0 = 16-bit, 1 = 18-bit |
| byte_i | input | 8 | Byte from the host port |
| byte_vld_i | input | 1 | byte_i carries a pixel byte this cycle |
| hs_n_i | input | 1 | Horizontal sync from the host, active low |
| vs_n_i | input | 1 | Vertical sync from the host, active low |
| rgb_o | output | 18 | Assembled pixel |
| de_o | output | 1 | One-cycle strobe for a new pixel on rgb_o |
| hs_n_o | output | 1 | Delayed horizontal sync |
| vs_n_o | output | 1 | Delayed vertical sync |

## Verification
The bench measures the cycle of the first data-enable and of each delayed sync edge in both formats. A design that used a single delay for both formats would be two clocks late or early in one of them, and the panel image would shift sideways. It sends a stray byte before a sync pulse, and also a byte in the same cycle as the sync falling edge. A phase counter that ignored the sync, or dropped that byte, would mix bytes from two pixels and swap colour channels. Gaps in byte_vld_i in the middle of a pixel check that the output holds its value and that no extra strobe appears. A full 320-pixel line checks that the strobe count matches the pixel count.

// File: rtl/pxa_pkg.sv
package pxa_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CH_W   = 6;
  localparam int unsigned PIX_W  = 3 * CH_W;
  localparam int unsigned NB_565 = 2;
  localparam int unsigned NB_888 = 3;
  localparam int unsigned WIN_W  = NB_888 * BYTE_W;

  typedef enum logic {FMT_565 = 1'b0, FMT_888 = 1'b1} fmt_e;

  function automatic logic [PIX_W-1:0] pack_pix(input fmt_e fmt, input logic wide,
                                                input logic [WIN_W-1:0] win);
    logic [4:0] r5, b5;
    logic [5:0] r6, g6, b6;
    if (fmt == FMT_565) begin
      r5 = win[15:11];
      g6 = win[10:5];
      b5 = win[4:0];
      r6 = {r5, r5[4]};
      b6 = {b5, b5[4]};
    end else begin
      r5 = win[23:19];
      g6 = win[15:10];
      b5 = win[7:3];
      r6 = win[23:18];
      b6 = win[7:2];
    end
    return wide ? {r6, g6, b6} : {2'b00, r5, g6, b5};
  endfunction
endpackage

// File: rtl/pxa_phase.sv
module pxa_phase
  import pxa_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  fmt_e             fmt_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic             vld_i,
  input  logic             hs_n_i,
  output logic [WIN_W-1:0] win_o,
  output logic             done_o
);
  localparam int unsigned PH_W = $clog2(NB_888);
  localparam logic [PH_W-1:0] LAST_565 = PH_W'(NB_565 - 1);
  localparam logic [PH_W-1:0] LAST_888 = PH_W'(NB_888 - 1);

  logic [PH_W-1:0] ph_q, ph_eff, last;
  logic            hs_prev_q, fall, at_last;

  assign last    = (fmt_i == FMT_888) ? LAST_888 : LAST_565;
  assign fall    = hs_prev_q & ~hs_n_i;
  assign ph_eff  = fall ? '0 : ph_q;
  assign at_last = (ph_eff == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= '0;
      hs_prev_q <= 1'b1;
      win_o     <= '0;
      done_o    <= 1'b0;
    end else begin
      hs_prev_q <= hs_n_i;
      done_o    <= vld_i & at_last;
      if (vld_i) begin
        win_o <= {win_o[WIN_W-BYTE_W-1:0], byte_i};
        ph_q  <= at_last ? '0 : ph_eff + 1'b1;
      end else begin
        ph_q  <= ph_eff;
      end
    end
  end
endmodule

// File: rtl/pxa_pixpipe.sv
module pxa_pixpipe
  import pxa_pkg::*;
#(
  parameter int unsigned STAGES = 2,
  parameter int unsigned TAP_A  = 0,
  parameter int unsigned TAP_B  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  fmt_e             fmt_i,
  input  logic             wide_i,
  input  logic [WIN_W-1:0] win_i,
  input  logic             done_i,
  output logic [PIX_W-1:0] rgb_o,
  output logic             de_o
);
  logic [PIX_W-1:0] st_pix [STAGES];
  logic [STAGES-1:0] st_v;
  logic [PIX_W-1:0] tap_pix;
  logic             tap_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_v[0]   <= 1'b0;
      st_pix[0] <= '0;
    end else begin
      st_v[0] <= done_i;
      if (done_i) st_pix[0] <= pack_pix(fmt_i, wide_i, win_i);
    end
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_v[k]   <= 1'b0;
        st_pix[k] <= '0;
      end else begin
        st_v[k]   <= st_v[k-1];
        st_pix[k] <= st_pix[k-1];
      end
    end
  end

  assign tap_v   = (fmt_i == FMT_888) ? st_v[TAP_B]   : st_v[TAP_A];
  assign tap_pix = (fmt_i == FMT_888) ? st_pix[TAP_B] : st_pix[TAP_A];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_o  <= 1'b0;
      rgb_o <= '0;
    end else begin
      de_o <= tap_v;
      if (tap_v) rgb_o <= tap_pix;
    end
  end
endmodule

// File: rtl/pxa_sync_dly.sv
module pxa_sync_dly #(
  parameter int unsigned W       = 2,
  parameter int unsigned DEPTH   = 6,
  parameter logic [W-1:0] RST_VAL = '1,
  localparam int unsigned TAP_W  = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAP_W-1:0] tap_i,
  input  logic [W-1:0]     d_i,
  output logic [W-1:0]     q_o
);
  logic [W-1:0] line [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line[0] <= RST_VAL;
    else         line[0] <= d_i;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) line[k] <= RST_VAL;
      else         line[k] <= line[k-1];
    end
  end

  assign q_o = line[tap_i];
endmodule

// File: rtl/byte_pixel_assembler.sv
module byte_pixel_assembler
  import pxa_pkg::*;
#(
  parameter int unsigned LAT_565 = 3,
  parameter int unsigned LAT_888 = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fmt_i,
  input  logic              wide_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_vld_i,
  input  logic              hs_n_i,
  input  logic              vs_n_i,
  output logic [PIX_W-1:0]  rgb_o,
  output logic              de_o,
  output logic              hs_n_o,
  output logic              vs_n_o
);
  // pixel path: byte reg, done, (L-N) stages, output reg
  localparam int unsigned TAP_A  = LAT_565 - NB_565 - 1;
  localparam int unsigned TAP_B  = LAT_888 - NB_888 - 1;
  localparam int unsigned STAGES = ((TAP_A > TAP_B) ? TAP_A : TAP_B) + 1;
  localparam int unsigned SDEPTH = ((LAT_565 > LAT_888) ? LAT_565 : LAT_888) + 1;
  localparam int unsigned STAP_W = $clog2(SDEPTH);

  fmt_e             fmt;
  logic [WIN_W-1:0] win;
  logic             done;
  logic [STAP_W-1:0] stap;
  logic [1:0]       sync_q;

  assign fmt  = fmt_e'(fmt_i);
  assign stap = (fmt == FMT_888) ? STAP_W'(LAT_888) : STAP_W'(LAT_565);

  pxa_phase u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fmt_i  (fmt),
    .byte_i (byte_i),
    .vld_i  (byte_vld_i),
    .hs_n_i (hs_n_i),
    .win_o  (win),
    .done_o (done)
  );

  pxa_pixpipe #(.STAGES(STAGES), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fmt_i  (fmt),
    .wide_i (wide_i),
    .win_i  (win),
    .done_i (done),
    .rgb_o  (rgb_o),
    .de_o   (de_o)
  );

  pxa_sync_dly #(.W(2), .DEPTH(SDEPTH), .RST_VAL(2'b11)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tap_i  (stap),
    .d_i    ({vs_n_i, hs_n_i}),
    .q_o    (sync_q)
  );

  assign hs_n_o = sync_q[0];
  assign vs_n_o = sync_q[1];
endmodule

// File: rtl/pxa_checker.sv
module pxa_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        fmt_i,
  input logic        byte_vld_i,
  input logic        hs_n_i,
  input logic        vs_n_i,
  input logic [17:0] rgb_o,
  input logic        de_o,
  input logic        hs_n_o,
  input logic        vs_n_o
);
  logic [2:0] cnt_q;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q != 3'd7) cnt_q <= cnt_q + 3'd1;
  end
  assign warm = (cnt_q == 3'd7);

  assert_de_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |=> !de_o);

  assert_rgb_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> $stable(rgb_o));

  assert_hs_delay_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> (hs_n_o == (fmt_i ? $past(hs_n_i, 6) : $past(hs_n_i, 4))));

  assert_vs_delay_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> (vs_n_o == (fmt_i ? $past(vs_n_i, 6) : $past(vs_n_i, 4))));

  assert_de_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && de_o) |-> (fmt_i ? $past(byte_vld_i, 4) : $past(byte_vld_i, 3)));
endmodule

bind byte_pixel_assembler pxa_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fmt_i      (fmt_i),
  .byte_vld_i (byte_vld_i),
  .hs_n_i     (hs_n_i),
  .vs_n_i     (vs_n_i),
  .rgb_o      (rgb_o),
  .de_o       (de_o),
  .hs_n_o     (hs_n_o),
  .vs_n_o     (vs_n_o)
);

// File: tb/byte_pixel_assembler_tb.sv
module byte_pixel_assembler_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt = 1'b0, wide = 1'b0;
  logic [7:0]  byte_d = '0;
  logic        vld = 1'b0, hs_n = 1'b1, vs_n = 1'b1;
  logic [17:0] rgb;
  logic        de, hs_o, vs_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int cap_n = 0, dbl = 0, hs_first = -1, vs_first = -1;
  int cap_cyc [512];
  logic [17:0] cap_rgb [512];
  logic de_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_pixel_assembler u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .wide_i(wide),
    .byte_i(byte_d), .byte_vld_i(vld), .hs_n_i(hs_n), .vs_n_i(vs_n),
    .rgb_o(rgb), .de_o(de), .hs_n_o(hs_o), .vs_n_o(vs_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (de) begin
      if (cap_n < 512) begin
        cap_cyc[cap_n] = cyc;
        cap_rgb[cap_n] = rgb;
      end
      cap_n++;
      if (de_prev) dbl++;
    end
    de_prev = de;
    if (!hs_o && hs_first < 0) hs_first = cyc;
    if (!vs_o && vs_first < 0) vs_first = cyc;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] exp565(input logic [15:0] w, input logic wd);
    return wd ? {w[15:11], w[15], w[10:5], w[4:0], w[4]} : {2'b00, w};
  endfunction

  function automatic logic [17:0] exp888(input logic [7:0] r, g, b, input logic wd);
    return wd ? {r[7:2], g[7:2], b[7:2]} : {2'b00, r[7:3], g[7:2], b[7:3]};
  endfunction

  task automatic put(input logic [7:0] b);
    byte_d = b; vld = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic f, input logic w);
    fmt = f; wide = w;
    idle(8);
    cap_n = 0; dbl = 0;
  endtask

  task automatic t_reset;
    chk(rgb == '0 && de == 1'b0, "R9 rgb/de", {rgb, de}, 0);
    chk(hs_o && vs_o, "R9 syncs", {hs_o, vs_o}, 3);
  endtask

  task automatic t_565(input logic w);
    logic [15:0] px [3] = '{16'hA5C3, 16'h1234, 16'hFFFF};
    int c0;
    setup(1'b0, w);
    c0 = cyc;
    foreach (px[i]) begin put(px[i][15:8]); put(px[i][7:0]); end
    idle(8);
    chk(cap_n == 3, "R6 count 565", cap_n, 3);
    chk(cap_cyc[0] == c0 + 1 + 3, "R4 latency 565", cap_cyc[0], c0 + 4);
    chk(cap_cyc[1] == c0 + 1 + 3 + 2, "R4 spacing 565", cap_cyc[1], c0 + 6);
    for (int i = 0; i < 3; i++)
      chk(cap_rgb[i] == exp565(px[i], w), w ? "R3 wide 565" : "R1 565 value",
          cap_rgb[i], exp565(px[i], w));
  endtask

  task automatic t_888(input logic w);
    logic [7:0] r [2] = '{8'hF3, 8'h0C};
    logic [7:0] g [2] = '{8'h5A, 8'hE7};
    logic [7:0] b [2] = '{8'h81, 8'h7E};
    int c0;
    setup(1'b1, w);
    c0 = cyc;
    for (int i = 0; i < 2; i++) begin put(r[i]); put(g[i]); put(b[i]); end
    idle(10);
    chk(cap_n == 2, "R6 count 888", cap_n, 2);
    chk(cap_cyc[0] == c0 + 1 + 5, "R4 latency 888", cap_cyc[0], c0 + 6);
    for (int i = 0; i < 2; i++)
      chk(cap_rgb[i] == exp888(r[i], g[i], b[i], w), w ? "R3 wide 888" : "R2 888 value",
          cap_rgb[i], exp888(r[i], g[i], b[i], w));
  endtask

  task automatic t_gap;
    int c1;
    setup(1'b0, 1'b0);
    put(8'h3C); put(8'h71);
    idle(6);
    put(8'hC8);
    idle(6);
    chk(cap_n == 1 && rgb == exp565(16'h3C71, 1'b0), "R7 hold in gap", rgb, exp565(16'h3C71, 1'b0));
    c1 = cyc;
    put(8'h0F);
    idle(6);
    chk(cap_n == 2, "R7 count after gap", cap_n, 2);
    chk(cap_cyc[1] == c1 + 1 + 2, "R7 last-byte timing", cap_cyc[1], c1 + 3);
    chk(cap_rgb[1] == exp565(16'hC80F, 1'b0), "R7 gap pixel", cap_rgb[1], exp565(16'hC80F, 1'b0));
  endtask

  task automatic t_realign;
    setup(1'b1, 1'b0);
    put(8'h99);
    vld = 1'b0; hs_n = 1'b0;
    idle(2);
    hs_n = 1'b1;
    idle(2);
    put(8'hE0); put(8'h44); put(8'h18);
    idle(10);
    chk(cap_n == 1, "R8 realign count 888", cap_n, 1);
    chk(cap_rgb[0] == exp888(8'hE0, 8'h44, 8'h18, 1'b0), "R8 realign 888",
        cap_rgb[0], exp888(8'hE0, 8'h44, 8'h18, 1'b0));
    setup(1'b0, 1'b0);
    put(8'h55);
    hs_n = 1'b0; put(8'hB6);
    put(8'h2D);
    hs_n = 1'b1;
    idle(8);
    chk(cap_n == 1, "R8 same-cycle count", cap_n, 1);
    chk(cap_rgb[0] == exp565(16'hB62D, 1'b0), "R8 byte on sync edge",
        cap_rgb[0], exp565(16'hB62D, 1'b0));
  endtask

  task automatic t_sync;
    int c0;
    setup(1'b0, 1'b0);
    hs_first = -1;
    c0 = cyc; hs_n = 1'b0;
    idle(2); hs_n = 1'b1; idle(8);
    chk(hs_first == c0 + 1 + 3, "R5 hsync 565", hs_first, c0 + 4);
    setup(1'b1, 1'b0);
    vs_first = -1;
    c0 = cyc; vs_n = 1'b0;
    idle(2); vs_n = 1'b1; idle(8);
    chk(vs_first == c0 + 1 + 5, "R5 vsync 888", vs_first, c0 + 6);
  endtask

  task automatic t_line;
    setup(1'b0, 1'b0);
    for (int i = 0; i < 320; i++) begin put(8'(i >> 3)); put(8'(i)); end
    idle(8);
    chk(cap_n == 320, "R10 line pulses", cap_n, 320);
    chk(dbl == 0, "R6 no back-to-back strobe", dbl, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_565(1'b0);
    t_565(1'b1);
    t_888(1'b0);
    t_888(1'b1);
    t_gap;
    t_realign;
    t_sync;
    t_line;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule